// File: doc/BRIEF.md
# Circuit Setup and Reconfiguration Table

This block sits in each router of a hybrid circuit/packet-switched mesh. Narrow setup packets arrive on a lightweight setup network. Each packet carries a circuit plane number and a destination node. For each packet, the block picks the output port with XY dimension-order routing, computed from the router's own coordinates. It records on that plane that the arriving input now drives that output, and it emits the packet again toward the chosen output. No acknowledgement is awaited, so data can follow the setup packet at once.

When the chosen output on that plane is already held by a different input, the old circuit is torn down and the output is reassigned in the same write. The block also removes the arriving input's earlier circuit on the same plane, so each input feeds at most one output per plane. Incoming setup packets wait in a small queue.

A two-state controller drains the queue. In `ST_IDLE` it pops the oldest packet when the queue is not empty, taking the `IDLE_TO_COMMIT` transition. In `ST_COMMIT` it presents the forwarded packet for one cycle and writes the table. It then always returns through `COMMIT_TO_IDLE`. The data path reads the table through a combinational lookup port.

Top module: `circuit_setup_table`

## Requirements
- R1: After reset, every table entry on every plane reads invalid through the lookup port, `fwd_valid_o` is low and `in_ready_o` is high.
- R2: The forwarded port is chosen XY-first. The destination x is `dest[1:0]` and y is `dest[3:2]`. The port codes are 0 local, 1 north, 2 east, 3 south, 4 west. x greater than the local x gives east, and x less than it gives west. With x equal, y greater gives north, y less gives south, and y equal gives local. The forwarded plane and destination equal those of the packet.
- R3: A packet accepted at clock edge k, with the controller idle and the queue empty, shows `fwd_valid_o` high for exactly one cycle, after edge k+1. Packets leave in the order they were accepted.
- R4: After the forward cycle ends, looking up that plane and the forwarded port shows valid, with the source equal to the packet's input port.
- R5: If the chosen output on the plane is held by a different input, the entry is overwritten and `teardown_o` is high during the forward cycle. Otherwise `teardown_o` stays low.
- R6: Any other output on the same plane whose valid entry names the same input port is made invalid by the same write.
- R7: A write on one plane leaves the entries of every other plane unchanged.
- R8: A packet naming a plane at or above `N_PLANES` is still forwarded. It changes no entry and raises no teardown.
- R9: The queue holds `FIFO_DEPTH` packets. `in_ready_o` is low exactly when it is full, and a packet offered while it is low is dropped.
- R10: A lookup naming a plane at or above `N_PLANES` returns invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Setup packet offered |
| in_ready_o | output | 1 | Queue can accept a packet |
| in_port_i | input | 3 | Input port the packet arrived on |
| in_plane_i | input | 2 | Circuit plane named by the packet |
| in_dest_i | input | 4 | Destination node, y in [3:2], x in [1:0] |
| fwd_valid_o | output | 1 | Forwarded packet present |
| fwd_port_o | output | 3 | Output port for the forwarded packet |
| fwd_plane_o | output | 2 | Plane of the forwarded packet |
| fwd_dest_o | output | 4 | Destination of the forwarded packet |
| teardown_o | output | 1 | An existing circuit was displaced |
| lk_plane_i | input | 2 | Lookup plane |
| lk_out_i | input | 3 | Lookup output port |
| lk_valid_o | output | 1 | Looked-up entry holds a circuit |
| lk_src_o | output | 3 | Input port driving the looked-up output |

## Verification
The bench builds the block with `N_PLANES` = 2, a queue depth of 4 and local coordinates (1,2). With two planes, packets and lookups naming planes 2 and 3 exercise the out-of-range path. Placing the node off every mesh edge makes all five routing outcomes reachable. Bursts that offer a packet every cycle fill the four-entry queue, which exercises back-pressure, dropping and in-order draining. Directed collisions on plane 0 cover teardown and the clearing of an input's earlier circuit, and repeating them on plane 1 covers plane independence.

// File: rtl/cset_pkg.sv
package cset_pkg;
    localparam int PORTS   = 5;
    localparam int PORT_W  = 3;
    localparam int PLANE_W = 2;
    localparam int DEST_W  = 4;
    localparam int COORD_W = DEST_W / 2;

    typedef enum logic [PORT_W-1:0] {
        P_LOCAL = 3'd0,
        P_NORTH = 3'd1,
        P_EAST  = 3'd2,
        P_SOUTH = 3'd3,
        P_WEST  = 3'd4
    } port_e;

    typedef struct packed {
        logic [PORT_W-1:0]  port;
        logic [PLANE_W-1:0] plane;
        logic [DEST_W-1:0]  dest;
    } setup_pkt_t;

    typedef struct packed {
        logic              vld;
        logic [PORT_W-1:0] src;
    } entry_t;
endpackage

// File: rtl/cset_fifo.sv
module cset_fifo #(
    parameter  int W     = 9,
    parameter  int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout = mem[rd_ptr];
endmodule

// File: rtl/cset_xy_route.sv
module cset_xy_route
    import cset_pkg::*;
#(
    parameter int LOC_X = 1,
    parameter int LOC_Y = 2
) (
    input  logic [DEST_W-1:0] dest,
    output port_e             port
);
    logic [COORD_W-1:0] dx, dy;

    always_comb begin
        dx = dest[COORD_W-1:0];
        dy = dest[DEST_W-1:COORD_W];
        if (dx > COORD_W'(LOC_X))      port = P_EAST;
        else if (dx < COORD_W'(LOC_X)) port = P_WEST;
        else if (dy > COORD_W'(LOC_Y)) port = P_NORTH;
        else if (dy < COORD_W'(LOC_Y)) port = P_SOUTH;
        else                           port = P_LOCAL;
    end
endmodule

// File: rtl/cset_table.sv
module cset_table
    import cset_pkg::*;
#(
    parameter int N_PLANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PLANE_W-1:0] wr_plane,
    input  logic [PORT_W-1:0]  wr_out,
    input  logic [PORT_W-1:0]  wr_src,
    output entry_t             occ,
    input  logic [PLANE_W-1:0] lk_plane,
    input  logic [PORT_W-1:0]  lk_out,
    output entry_t             lk
);
    entry_t ent [N_PLANES][PORTS];

    for (genvar p = 0; p < N_PLANES; p++) begin : g_plane
        for (genvar o = 0; o < PORTS; o++) begin : g_out
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ent[p][o] <= '0;
                end else if (wr_en && int'(wr_plane) == p) begin
                    if (int'(wr_out) == o)
                        ent[p][o] <= '{vld: 1'b1, src: wr_src};
                    else if (ent[p][o].vld && ent[p][o].src == wr_src)
                        ent[p][o].vld <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        occ = '0;
        lk  = '0;
        for (int p = 0; p < N_PLANES; p++) begin
            for (int o = 0; o < PORTS; o++) begin
                if (int'(wr_plane) == p && int'(wr_out) == o) occ = ent[p][o];
                if (int'(lk_plane) == p && int'(lk_out) == o) lk  = ent[p][o];
            end
        end
    end
endmodule

// File: rtl/circuit_setup_table.sv
module circuit_setup_table
    import cset_pkg::*;
#(
    parameter  int N_PLANES   = 4,
    parameter  int FIFO_DEPTH = 4,
    parameter  int LOC_X      = 1,
    parameter  int LOC_Y      = 2,
    localparam int PKT_W      = $bits(setup_pkt_t),
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid_i,
    output logic               in_ready_o,
    input  logic [PORT_W-1:0]  in_port_i,
    input  logic [PLANE_W-1:0] in_plane_i,
    input  logic [DEST_W-1:0]  in_dest_i,
    output logic               fwd_valid_o,
    output logic [PORT_W-1:0]  fwd_port_o,
    output logic [PLANE_W-1:0] fwd_plane_o,
    output logic [DEST_W-1:0]  fwd_dest_o,
    output logic               teardown_o,
    input  logic [PLANE_W-1:0] lk_plane_i,
    input  logic [PORT_W-1:0]  lk_out_i,
    output logic               lk_valid_o,
    output logic [PORT_W-1:0]  lk_src_o
);
    typedef enum logic {ST_IDLE, ST_COMMIT} state_e;

    state_e      state_q, state_d;
    setup_pkt_t  hold_q, q_head;
    logic [CNT_W-1:0] q_count;
    logic        q_push, q_pop, in_range, wr_en;
    port_e       route_port;
    entry_t      occ, lk;

    assign in_ready_o = (q_count != CNT_W'(FIFO_DEPTH));
    assign q_push     = in_valid_i && in_ready_o;
    assign q_pop      = (state_q == ST_IDLE) && (q_count != '0);
    assign in_range   = int'(hold_q.plane) < N_PLANES;

    cset_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   ({in_port_i, in_plane_i, in_dest_i}),
        .pop   (q_pop),
        .dout  (q_head),
        .count (q_count)
    );

    cset_xy_route #(.LOC_X(LOC_X), .LOC_Y(LOC_Y)) u_route (
        .dest (hold_q.dest),
        .port (route_port)
    );

    cset_table #(.N_PLANES(N_PLANES)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_plane (hold_q.plane),
        .wr_out   (route_port),
        .wr_src   (hold_q.port),
        .occ      (occ),
        .lk_plane (lk_plane_i),
        .lk_out   (lk_out_i),
        .lk       (lk)
    );

    // Next-state logic for the controller
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (q_pop) state_d = ST_COMMIT;   // IDLE_TO_COMMIT
            ST_COMMIT: state_d = ST_IDLE;                // COMMIT_TO_IDLE
        endcase
    end

    // State register and held packet
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (q_pop) hold_q <= q_head;
        end
    end

    // Outputs
    always_comb begin
        fwd_valid_o = 1'b0;
        wr_en       = 1'b0;
        teardown_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_COMMIT: begin
                fwd_valid_o = 1'b1;
                wr_en       = in_range;
                teardown_o  = in_range && occ.vld && (occ.src != hold_q.port);
            end
        endcase
        fwd_port_o  = route_port;
        fwd_plane_o = hold_q.plane;
        fwd_dest_o  = hold_q.dest;
        lk_valid_o  = lk.vld;
        lk_src_o    = lk.src;
    end
endmodule

// File: rtl/cset_checker.sv
module cset_checker
    import cset_pkg::*;
#(
    parameter  int N_PLANES   = 4,
    parameter  int FIFO_DEPTH = 4,
    parameter  int LOC_X      = 1,
    parameter  int LOC_Y      = 2,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_ready_o,
    input logic               fwd_valid_o,
    input logic [PORT_W-1:0]  fwd_port_o,
    input logic [PLANE_W-1:0] fwd_plane_o,
    input logic [DEST_W-1:0]  fwd_dest_o,
    input logic               teardown_o,
    input logic [PLANE_W-1:0] lk_plane_i,
    input logic               lk_valid_o,
    input logic [CNT_W-1:0]   q_count
);
    localparam logic [DEST_W-1:0] LOC_ID = DEST_W'(LOC_Y * 4 + LOC_X);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid_o |=> !fwd_valid_o);

    a_r5_teardown_in_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        teardown_o |-> fwd_valid_o);

    a_r8_no_teardown_range: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid_o && int'(fwd_plane_o) >= N_PLANES) |-> !teardown_o);

    a_r9_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CNT_W'(FIFO_DEPTH)) |-> !in_ready_o);

    a_r2_local_eject: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid_o && fwd_port_o == P_LOCAL) |-> fwd_dest_o == LOC_ID);

    a_r10_lookup_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lk_plane_i) >= N_PLANES) |-> !lk_valid_o);
endmodule

bind circuit_setup_table cset_checker #(
    .N_PLANES(N_PLANES), .FIFO_DEPTH(FIFO_DEPTH), .LOC_X(LOC_X), .LOC_Y(LOC_Y)
) u_cset_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready_o  (in_ready_o),
    .fwd_valid_o (fwd_valid_o),
    .fwd_port_o  (fwd_port_o),
    .fwd_plane_o (fwd_plane_o),
    .fwd_dest_o  (fwd_dest_o),
    .teardown_o  (teardown_o),
    .lk_plane_i  (lk_plane_i),
    .lk_valid_o  (lk_valid_o),
    .q_count     (q_count)
);

// File: tb/test_circuit_setup_table.sv
module test_circuit_setup_table;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 2;
    localparam int DEPTH = 4;
    localparam int LX = 1;
    localparam int LY = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid_i = 1'b0;
    logic       in_ready_o;
    logic [2:0] in_port_i = '0;
    logic [1:0] in_plane_i = '0;
    logic [3:0] in_dest_i = '0;
    logic       fwd_valid_o;
    logic [2:0] fwd_port_o;
    logic [1:0] fwd_plane_o;
    logic [3:0] fwd_dest_o;
    logic       teardown_o;
    logic [1:0] lk_plane_i = '0;
    logic [2:0] lk_out_i = '0;
    logic       lk_valid_o;
    logic [2:0] lk_src_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic       mv [4][5];
    logic [2:0] ms [4][5];

    always #(CLK_PERIOD / 2) clk = ~clk;

    circuit_setup_table #(.N_PLANES(NP), .FIFO_DEPTH(DEPTH), .LOC_X(LX), .LOC_Y(LY))
        i_circuit_setup_table (.*);

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected under 50000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_port(input logic [3:0] d);
        int x = int'(d[1:0]);
        int y = int'(d[3:2]);
        if (x > LX) return 2;
        if (x < LX) return 4;
        if (y > LY) return 1;
        if (y < LY) return 3;
        return 0;
    endfunction

    function automatic bit exp_tear(input logic [2:0] src, input logic [1:0] pl, input int o);
        return int'(pl) < NP && mv[pl][o] && ms[pl][o] != src;
    endfunction

    function automatic void model_write(input logic [2:0] src, input logic [1:0] pl, input int o);
        if (int'(pl) >= NP) return;
        for (int k = 0; k < 5; k++)
            if (k != o && mv[pl][k] && ms[pl][k] == src) mv[pl][k] = 1'b0;
        mv[pl][o] = 1'b1;
        ms[pl][o] = src;
    endfunction

    task automatic check_table(input string req);
        for (int p = 0; p < 4; p++) begin
            for (int o = 0; o < 5; o++) begin
                lk_plane_i = 2'(p);
                lk_out_i   = 3'(o);
                #1;
                chk(p >= NP ? "R10 lookup out of range" : req, int'(lk_valid_o), int'(mv[p][o]));
                if (mv[p][o]) chk(req, int'(lk_src_o), int'(ms[p][o]));
            end
        end
    endtask

    task automatic send_one(input logic [2:0] src, input logic [1:0] pl, input logic [3:0] d,
                            input string req);
        int o = exp_port(d);
        @(negedge clk);
        chk("R9 ready when empty", int'(in_ready_o), 1);
        in_valid_i = 1'b1; in_port_i = src; in_plane_i = pl; in_dest_i = d;
        @(negedge clk);
        in_valid_i = 1'b0;
        chk("R3 no forward before pop", int'(fwd_valid_o), 0);
        @(negedge clk);
        chk("R3 forward after pop", int'(fwd_valid_o), 1);
        chk("R2 route port", int'(fwd_port_o), o);
        chk("R2 plane kept", int'(fwd_plane_o), int'(pl));
        chk("R2 dest kept", int'(fwd_dest_o), int'(d));
        chk(int'(pl) >= NP ? "R8 no teardown" : "R5 teardown flag", int'(teardown_o),
            int'(exp_tear(src, pl, o)));
        model_write(src, pl, o);
        @(negedge clk);
        chk("R3 single cycle", int'(fwd_valid_o), 0);
        check_table(req);
    endtask

    task automatic burst();
        logic [8:0] acc [40];
        logic [8:0] got [40];
        int na = 0, ng = 0;
        bit saw_full = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (fwd_valid_o) begin
                got[ng] = {fwd_port_o, fwd_plane_o, fwd_dest_o};
                // teardown checked in order against the model
                if (ng < na) begin
                    chk("R5 burst teardown", int'(teardown_o),
                        int'(exp_tear(acc[ng][8:6], acc[ng][5:4], exp_port(acc[ng][3:0]))));
                    model_write(acc[ng][8:6], acc[ng][5:4], exp_port(acc[ng][3:0]));
                end
                ng++;
            end
            if (c < 14) begin
                in_valid_i = 1'b1;
                in_port_i  = 3'($urandom_range(0, 4));
                in_plane_i = 2'($urandom_range(0, 3));
                in_dest_i  = 4'($urandom_range(0, 15));
                if (in_ready_o) begin
                    acc[na] = {in_port_i, in_plane_i, in_dest_i};
                    na++;
                end else saw_full = 1;
            end else in_valid_i = 1'b0;
        end
        chk("R9 queue fills under burst", int'(saw_full), 1);
        chk("R9 accepted count forwarded", ng, na);
        for (int i = 0; i < na && i < ng; i++) begin
            chk("R3 order port", int'(got[i][8:6]), exp_port(acc[i][3:0]));
            chk("R3 order plane/dest", int'(got[i][5:0]), int'(acc[i][5:0]));
        end
        check_table("R4 table after burst");
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int p = 0; p < 4; p++)
            for (int o = 0; o < 5; o++) begin mv[p][o] = 1'b0; ms[p][o] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 no forward after reset", int'(fwd_valid_o), 0);
        chk("R1 ready after reset", int'(in_ready_o), 1);
        check_table("R1 table empty after reset");

        // R2 every direction from node (1,2)
        send_one(3'd0, 2'd0, 4'd11, "R4 east");   // x=3 -> east
        send_one(3'd1, 2'd0, 4'd8,  "R4 west");   // x=0 -> west
        send_one(3'd2, 2'd0, 4'd13, "R4 north");  // y=3 -> north
        send_one(3'd4, 2'd0, 4'd1,  "R4 south");  // y=0 -> south
        send_one(3'd3, 2'd0, 4'd9,  "R4 local");  // own node
        send_one(3'd1, 2'd0, 4'd3,  "R2 x first"); // x=3,y=0 -> east
        // R5 another input claims east on plane 0
        send_one(3'd3, 2'd0, 4'd7,  "R5 reconfigure east");
        // R6 input 3 moves to west: its east circuit is cleared
        send_one(3'd3, 2'd0, 4'd4,  "R6 old circuit cleared");
        // R7 plane 1 collisions leave plane 0 alone
        send_one(3'd2, 2'd1, 4'd11, "R7 plane 1 east");
        send_one(3'd0, 2'd1, 4'd11, "R7 plane 1 reconfigure");
        // R8 plane beyond N_PLANES
        send_one(3'd4, 2'd3, 4'd11, "R8 out-of-range plane");
        send_one(3'd4, 2'd2, 4'd9,  "R8 out-of-range plane 2");
        // same input same output: no teardown
        send_one(3'd0, 2'd1, 4'd15, "R5 same source rewrite");

        burst();

        for (int i = 0; i < 120; i++)
            send_one(3'($urandom_range(0, 4)), 2'($urandom_range(0, 3)),
                     4'($urandom_range(0, 15)), "R4 random");

        burst();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule